// File: doc/BRIEF.md
# Pointer-Addressed Sensor Register Slave

This block is the two-wire serial slave of a temperature sensor. It watches already filtered clock and data lines. It answers one 7-bit address whose upper four bits are fixed at `0011` and whose lower three bits come from board select pins. Behind that address sits a bank of 16-bit registers: configuration, three temperature limits, a resolution setting, the live temperature word and fixed identity words. The slave only pulls the data line low. It never drives the clock.

A latched pointer selects the register that a transfer works on. A write transfer always carries the pointer byte first. Two more data bytes, most significant first, then update the selected register. A read transfer carries no pointer byte. It returns the selected word, high byte first. To read another register, the master writes only the pointer, issues a repeated START and then reads. The configuration word holds two lock bits. Once set, each stays set until reset. The locks make some limits read-only and freeze some configuration fields, so that firmware cannot loosen thermal protection later.

Top module: `smb_sensor_regs`

## Requirements
- R1: The slave acknowledges an address byte whose 7-bit address is `{4'b0011, sel_pins_i}`. It does not acknowledge any other address, and such a transfer changes no register.
- R2: The pointer resets to 0x00 and keeps its last written value. Reads never advance it. A read with no pointer phase returns the word that the pointer currently selects.
- R3: In a write, the first byte after the address loads the pointer. The register changes only when the second data byte arrives, with the first data byte as its upper half. A transfer stopped after a single data byte changes nothing. Data bytes after the second are acknowledged and dropped.
- R4: A read sends the high byte, then the low byte. If the master keeps acknowledging, the same two bytes repeat. A master NACK ends the read, and the slave releases SDA.
- R5: Read-only words: pointer 0x00 is `0x0067 | res<<3`, which is 0x0077 at reset. Pointer 0x05 is `{temp_flags_i[2:0], temp_i[12:0]}`. Pointer 0x06 is 0x00B3. Pointer 0x07 is 0x2913. Writes to these pointers are discarded. Any pointer above 0x08 reads 0x0000.
- R6: The limits (pointers 0x02 high, 0x03 low, 0x04 critical) keep only bits 12..2, and all other bits read 0. Resolution (pointer 0x08) keeps only bits 4..3. Its reset value is 0x0010.
- R7: The configuration word (pointer 0x01) has these fields: bits 10..9 hysteresis, bit 8 shutdown, bit 7 critical lock, bit 6 event lock, bit 5 clear, bit 4 status, bit 3 enable, bit 2 critical-only, bit 1 polarity, bit 0 interrupt mode. Bits 15..11 read 0. Bit 4 reads `evt_active_i`. Bit 5 reads 0, and writing it as 1 gives exactly one `evt_clear_o` pulse.
- R8: While the event lock is set, writes to the high and low limits and to the critical-only bit are discarded. While the critical lock is set, writes to the critical limit are discarded.
- R9: While either lock is set, hysteresis and enable hold their values, and shutdown can be cleared but not set. Each write is judged against the lock state from before that write.
- R10: Writing 1 to a lock bit sets it. Only reset clears it.
- R11: SDA is pulled low only during an acknowledge bit or a read data bit. It is released in the cycle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Filtered serial clock |
| sda_i | input | 1 | Filtered serial data |
| sel_pins_i | input | 3 | Low three address bits |
| temp_i | input | 13 | Signed temperature, 0.0625 C per LSB field |
| temp_flags_i | input | 3 | Critical, high and low flags for the temperature word |
| evt_active_i | input | 1 | Event output currently asserted |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| hyst_o | output | 2 | Hysteresis select |
| shdn_o | output | 1 | Shutdown |
| crit_lock_o | output | 1 | Critical limit lock |
| evt_lock_o | output | 1 | High/low limit lock |
| evt_clear_o | output | 1 | One-cycle event clear pulse |
| evt_en_o | output | 1 | Event output enable |
| crit_only_o | output | 1 | Event on critical limit only |
| evt_pol_o | output | 1 | Event polarity, 1 = active high |
| evt_int_mode_o | output | 1 | 1 = interrupt mode, 0 = comparator |
| high_lim_o | output | 16 | High limit |
| low_lim_o | output | 16 | Low limit |
| crit_lim_o | output | 16 | Critical limit |
| res_o | output | 2 | Resolution select |

## Verification
A single configuration write can set a lock and also change the very fields that the lock guards. So the lock update and the field update land in the same clock edge. The bench provokes this with one word that sets the event lock together with new hysteresis, enable, critical-only and shutdown values. It expects every new value to take effect, because the old lock state governs that write. It then expects the following writes to those fields and to the high/low limits to be refused, and it reads everything back over the bus. A second case in the same sequence clears shutdown while locked, and then tries to set it again.

// File: rtl/smb_sensor_pkg.sv
`timescale 1ns/1ps
package smb_sensor_pkg;
  localparam int REG_W = 16;
  localparam int BYTE_W = 8;
  localparam int TEMP_W = 13;
  localparam int FLAG_W = REG_W - TEMP_W;

  localparam logic [BYTE_W-1:0] PTR_CAP  = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_CFG  = 8'h01;
  localparam logic [BYTE_W-1:0] PTR_HIGH = 8'h02;
  localparam logic [BYTE_W-1:0] PTR_LOW  = 8'h03;
  localparam logic [BYTE_W-1:0] PTR_CRIT = 8'h04;
  localparam logic [BYTE_W-1:0] PTR_TEMP = 8'h05;
  localparam logic [BYTE_W-1:0] PTR_MFR  = 8'h06;
  localparam logic [BYTE_W-1:0] PTR_DEV  = 8'h07;
  localparam logic [BYTE_W-1:0] PTR_RES  = 8'h08;

  localparam logic [REG_W-1:0] LIM_KEEP = 16'h1FFC;
  localparam logic [1:0] RES_RESET = 2'b10;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shdn;
    logic       crit_lock;
    logic       evt_lock;
    logic       evt_en;
    logic       crit_only;
    logic       pol;
    logic       int_mode;
  } cfg_t;

  // Next configuration after a write; locks judged on the current value.
  function automatic cfg_t cfg_next(cfg_t cur, logic [REG_W-1:0] wd);
    cfg_t n;
    logic any_lock;
    any_lock    = cur.crit_lock | cur.evt_lock;
    n           = cur;
    n.pol       = wd[1];
    n.int_mode  = wd[0];
    n.crit_lock = cur.crit_lock | wd[7];
    n.evt_lock  = cur.evt_lock | wd[6];
    if (!any_lock) begin
      n.hyst   = wd[10:9];
      n.evt_en = wd[3];
    end
    if (!cur.evt_lock) n.crit_only = wd[2];
    n.shdn = any_lock ? (cur.shdn & wd[8]) : wd[8];
    return n;
  endfunction

  function automatic logic [REG_W-1:0] cfg_word(cfg_t c, logic sts);
    return {5'b0, c.hyst, c.shdn, c.crit_lock, c.evt_lock, 1'b0, sts,
            c.evt_en, c.crit_only, c.pol, c.int_mode};
  endfunction

  function automatic logic [REG_W-1:0] cap_word(logic [1:0] res);
    return {8'h00, 3'b011, res, 3'b111};
  endfunction

  function automatic logic [REG_W-1:0] res_word(logic [1:0] res);
    return {11'b0, res, 3'b000};
  endfunction

  function automatic logic [REG_W-1:0] lim_store(logic [REG_W-1:0] w);
    return w & LIM_KEEP;
  endfunction

  function automatic logic addr_hit(logic [6:0] a, logic [3:0] base, logic [2:0] pins);
    return a == {base, pins};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(logic [REG_W-1:0] w, logic low_half);
    return low_half ? w[7:0] : w[15:8];
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;
  logic scl_c, scl_p, sda_c, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_c = scl_sh[DEPTH-2];
  assign scl_p = scl_sh[DEPTH-1];
  assign sda_c = sda_sh[DEPTH-2];
  assign sda_p = sda_sh[DEPTH-1];

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/smb_byte_engine.sv
`timescale 1ns/1ps
module smb_byte_engine
  import smb_sensor_pkg::*;
#(
  parameter logic [3:0] BASE_ADDR = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        pins,
  input  logic [REG_W-1:0]  rd_word,
  output logic              sda_pull_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic [1:0]        wr_idx_o,
  output logic              rd_start_o
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDATA, S_ACK, S_TX, S_MACK} st_t;

  st_t              st;
  logic [2:0]       cnt;
  logic [BYTE_W-1:0] sh;
  logic             rd_mode, ack_on, sel, mack;
  logic [1:0]       idx;
  logic [BYTE_W-1:0] full, next_b;

  assign full   = {sh[6:0], sda_s};
  assign next_b = pick_byte(rd_word, ~sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rd_mode <= 1'b0; ack_on <= 1'b0;
      sel <= 1'b0; mack <= 1'b0; idx <= '0; sda_pull_o <= 1'b0;
      wr_stb_o <= 1'b0; wr_byte_o <= '0; wr_idx_o <= '0; rd_start_o <= 1'b0;
    end else begin
      wr_stb_o   <= 1'b0;
      rd_start_o <= 1'b0;
      if (start_evt) begin
        st <= S_ADDR; cnt <= '0; sda_pull_o <= 1'b0; ack_on <= 1'b0;
      end else if (stop_evt) begin
        st <= S_IDLE; sda_pull_o <= 1'b0; ack_on <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDATA: begin
            if (scl_rise) begin
              sh  <= full;
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                if (st == S_ADDR) begin
                  if (addr_hit(full[7:1], BASE_ADDR, pins)) begin
                    st <= S_ACK; rd_mode <= full[0]; idx <= '0; sel <= 1'b0;
                    rd_start_o <= full[0];
                  end else begin
                    st <= S_IDLE;
                  end
                end else begin
                  st <= S_ACK; wr_stb_o <= 1'b1; wr_byte_o <= full; wr_idx_o <= idx;
                  if (idx != 2'd3) idx <= idx + 2'd1;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_pull_o <= 1'b1; ack_on <= 1'b1;
              end else begin
                ack_on <= 1'b0; cnt <= '0;
                if (rd_mode) begin
                  sh <= pick_byte(rd_word, sel);
                  sda_pull_o <= ~pick_byte(rd_word, sel)[7];
                  st <= S_TX;
                end else begin
                  sda_pull_o <= 1'b0; st <= S_WDATA;
                end
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_pull_o <= 1'b0; st <= S_MACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_pull_o <= ~sh[6]; cnt <= cnt + 3'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sel <= ~sel; sh <= next_b; sda_pull_o <= ~next_b[7]; cnt <= '0; st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R4: an idle slave never holds the data line
  p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull_o);
  // R11: a STOP frees the line on the next cycle
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);
  // R11: the line is pulled only while acknowledging or sending data
  p_pull_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (st == S_ACK || st == S_TX));
  // R3: data bytes are delivered only inside an addressed write
  p_wr_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (st == S_ACK && !rd_mode));
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank
  import smb_sensor_pkg::*;
#(
  parameter logic [REG_W-1:0] MFR_ID = 16'h00B3,
  parameter logic [REG_W-1:0] DEV_ID = 16'h2913
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [1:0]        wr_idx,
  input  logic              rd_start,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              evt_active_i,
  output logic [REG_W-1:0]  rd_word_o,
  output cfg_t              cfg_o,
  output logic [REG_W-1:0]  high_o,
  output logic [REG_W-1:0]  low_o,
  output logic [REG_W-1:0]  crit_o,
  output logic [1:0]        res_o,
  output logic              clr_o
);
  logic [BYTE_W-1:0] ptr_q, msb_q;
  cfg_t              cfg_q;
  logic [REG_W-1:0]  high_q, low_q, crit_q, rd_mux, wr_word;
  logic [1:0]        res_q;
  logic              clr_q, commit;

  assign wr_word = {msb_q, wr_byte};
  assign commit  = wr_stb && (wr_idx == 2'd2);

  always_comb begin
    case (ptr_q)
      PTR_CAP:  rd_mux = cap_word(res_q);
      PTR_CFG:  rd_mux = cfg_word(cfg_q, evt_active_i);
      PTR_HIGH: rd_mux = high_q;
      PTR_LOW:  rd_mux = low_q;
      PTR_CRIT: rd_mux = crit_q;
      PTR_TEMP: rd_mux = {flags_i, temp_i};
      PTR_MFR:  rd_mux = MFR_ID;
      PTR_DEV:  rd_mux = DEV_ID;
      PTR_RES:  rd_mux = res_word(res_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= PTR_CAP; msb_q <= '0; cfg_q <= '0; high_q <= '0; low_q <= '0;
      crit_q <= '0; res_q <= RES_RESET; clr_q <= 1'b0; rd_word_o <= '0;
    end else begin
      clr_q <= 1'b0;
      if (wr_stb && wr_idx == 2'd0) ptr_q <= wr_byte;
      if (wr_stb && wr_idx == 2'd1) msb_q <= wr_byte;
      if (commit) begin
        case (ptr_q)
          PTR_CFG: begin
            cfg_q <= cfg_next(cfg_q, wr_word);
            clr_q <= wr_word[5];
          end
          PTR_HIGH: if (!cfg_q.evt_lock)  high_q <= lim_store(wr_word);
          PTR_LOW:  if (!cfg_q.evt_lock)  low_q  <= lim_store(wr_word);
          PTR_CRIT: if (!cfg_q.crit_lock) crit_q <= lim_store(wr_word);
          PTR_RES:  res_q <= wr_word[4:3];
          default: ;
        endcase
      end
      if (rd_start) rd_word_o <= rd_mux;
    end
  end

  assign cfg_o  = cfg_q;
  assign high_o = high_q;
  assign low_o  = low_q;
  assign crit_o = crit_q;
  assign res_o  = res_q;
  assign clr_o  = clr_q;

  // R10: locks are sticky
  p_crit_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.crit_lock |=> cfg_q.crit_lock);
  p_evt_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.evt_lock |=> cfg_q.evt_lock);
  // R8: locked limits hold still
  p_high_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.evt_lock |=> $stable(high_q) && $stable(low_q) && $stable(cfg_q.crit_only));
  p_crit_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.crit_lock |=> $stable(crit_q));
  // R9: under any lock, hysteresis and enable hold and shutdown cannot rise
  p_hyst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.crit_lock || cfg_q.evt_lock) |=> $stable(cfg_q.hyst) && $stable(cfg_q.evt_en));
  p_shdn_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q.crit_lock || cfg_q.evt_lock) && !cfg_q.shdn) |=> !cfg_q.shdn);
  // R7: clear is a single-cycle pulse
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  // R6: limit bits outside 12..2 stay zero
  p_limit_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((high_q | low_q | crit_q) & ~LIM_KEEP) == '0);
endmodule

// File: rtl/smb_sensor_regs.sv
`timescale 1ns/1ps
module smb_sensor_regs
  import smb_sensor_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  BASE_ADDR   = 4'b0011,
  parameter logic [15:0] MFR_ID      = 16'h00B3,
  parameter logic [15:0] DEV_ID      = 16'h2913
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  sel_pins_i,
  input  logic [12:0] temp_i,
  input  logic [2:0]  temp_flags_i,
  input  logic        evt_active_i,
  output logic        sda_pull_o,
  output logic [1:0]  hyst_o,
  output logic        shdn_o,
  output logic        crit_lock_o,
  output logic        evt_lock_o,
  output logic        evt_clear_o,
  output logic        evt_en_o,
  output logic        crit_only_o,
  output logic        evt_pol_o,
  output logic        evt_int_mode_o,
  output logic [15:0] high_lim_o,
  output logic [15:0] low_lim_o,
  output logic [15:0] crit_lim_o,
  output logic [1:0]  res_o
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_stb, rd_start;
  logic [BYTE_W-1:0] wr_byte;
  logic [1:0] wr_idx;
  logic [REG_W-1:0] rd_word;
  cfg_t cfg;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_evt), .stop_o(stop_evt));

  smb_byte_engine #(.BASE_ADDR(BASE_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .pins(sel_pins_i), .rd_word(rd_word),
    .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte), .wr_idx_o(wr_idx),
    .rd_start_o(rd_start));

  smb_reg_bank #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte), .wr_idx(wr_idx),
    .rd_start(rd_start), .temp_i(temp_i), .flags_i(temp_flags_i),
    .evt_active_i(evt_active_i), .rd_word_o(rd_word), .cfg_o(cfg),
    .high_o(high_lim_o), .low_o(low_lim_o), .crit_o(crit_lim_o), .res_o(res_o),
    .clr_o(evt_clear_o));

  assign hyst_o         = cfg.hyst;
  assign shdn_o         = cfg.shdn;
  assign crit_lock_o    = cfg.crit_lock;
  assign evt_lock_o     = cfg.evt_lock;
  assign evt_en_o       = cfg.evt_en;
  assign crit_only_o    = cfg.crit_only;
  assign evt_pol_o      = cfg.pol;
  assign evt_int_mode_o = cfg.int_mode;
endmodule

// File: tb/tb_smb_sensor_regs.sv
`timescale 1ns/1ps
module tb_smb_sensor_regs;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b0011_101;
  localparam logic [6:0] BAD = 7'b0011_110;
  localparam int NV = 13;
  // {pointer, written word, expected read-back}
  localparam logic [39:0] VEC [NV] = '{
    {8'h02, 16'hFFFF, 16'h1FFC},   // R6 limit mask
    {8'h03, 16'h0C6B, 16'h0C68},   // R6
    {8'h04, 16'h1234, 16'h1234},   // R6
    {8'h08, 16'hFFFF, 16'h0018},   // R6 resolution field
    {8'h08, 16'h0008, 16'h0008},   // R6
    {8'h00, 16'h1234, 16'h006F},   // R5 capability mirrors resolution
    {8'h06, 16'h0000, 16'h00B3},   // R5
    {8'h07, 16'hFFFF, 16'h2913},   // R5
    {8'h05, 16'hFFFF, 16'hA195},   // R5 temperature word
    {8'h0A, 16'hBEEF, 16'h0000},   // R5 unused pointer
    {8'h01, 16'h0607, 16'h0607},   // R7 configuration fields
    {8'h01, 16'h0020, 16'h0000},   // R7 clear reads zero
    {8'h08, 16'h0010, 16'h0010}    // R6
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic [2:0] pins = 3'b101;
  logic [12:0] temp = 13'h0195;
  logic [2:0] flags = 3'b101;
  logic evt_act = 1'b0;
  wire sda_pull, sda_line;
  wire [1:0] hyst, res;
  wire shdn, clock_l, elock, eclr, een, conly, epol, emode;
  wire [15:0] hi_l, lo_l, cr_l;
  int n_chk = 0, n_bad = 0, clr_cnt = 0;

  assign sda_line = ~(m_low | sda_pull);

  smb_sensor_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sel_pins_i(pins),
    .temp_i(temp), .temp_flags_i(flags), .evt_active_i(evt_act), .sda_pull_o(sda_pull),
    .hyst_o(hyst), .shdn_o(shdn), .crit_lock_o(clock_l), .evt_lock_o(elock),
    .evt_clear_o(eclr), .evt_en_o(een), .crit_only_o(conly), .evt_pol_o(epol),
    .evt_int_mode_o(emode), .high_lim_o(hi_l), .low_lim_o(lo_l), .crit_lim_o(cr_l),
    .res_o(res));

  always @(negedge clk) if (rst_n && eclr) clr_cnt++;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic b_start(); m_low = 0; qw(); m_scl = 1; qw(); m_low = 1; qw(); m_scl = 0; qw(); endtask
  task automatic b_stop(); m_low = 1; qw(); m_scl = 1; qw(); m_low = 0; qw(); endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(); m_scl = 1; qw(); qw(); m_scl = 0; qw();
    end
    m_low = 0; qw(); m_scl = 1; qw(); ack = ~sda_line; qw(); m_scl = 0; qw();
  endtask

  task automatic rx(input logic ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      qw(); m_scl = 1; qw(); b[i] = sda_line; qw(); m_scl = 0; qw();
    end
    m_low = ack; qw(); m_scl = 1; qw(); qw(); m_scl = 0; qw(); m_low = 0;
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [7:0] p, input logic [15:0] w,
                         output logic ok);
    logic k0, k1, k2, k3;
    b_start(); tx({a, 1'b0}, k0); tx(p, k1); tx(w[15:8], k2); tx(w[7:0], k3); b_stop();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic k0, k1;
    b_start(); tx({DEV, 1'b0}, k0); tx(p, k1); b_stop();
  endtask

  task automatic rd_cur(output logic [15:0] w);
    logic k;
    b_start(); tx({DEV, 1'b1}, k); rx(1'b1, w[15:8]); rx(1'b0, w[7:0]); b_stop();
  endtask

  task automatic rd_at(input logic [7:0] p, output logic [15:0] w);
    logic k0, k1, k2;
    b_start(); tx({DEV, 1'b0}, k0); tx(p, k1);
    b_start(); tx({DEV, 1'b1}, k2); rx(1'b1, w[15:8]); rx(1'b0, w[7:0]); b_stop();
  endtask

  task automatic fin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    fin();
  end

  initial begin
    logic [15:0] w, w2;
    logic [7:0] b0, b1, b2, b3;
    logic ok, k;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // reset state
    chk("R11 reset SDA released", {15'b0, sda_pull}, 16'h0);
    chk("R6 reset resolution", {14'b0, res}, 16'h0002);
    chk("R7 reset config outputs",
        {6'b0, hyst, shdn, clock_l, elock, een, conly, epol, emode, eclr}, 16'h0);
    rd_cur(w);
    chk("R2 R5 read without pointer phase after reset", w, 16'h0077);

    // address decode
    wr_word(BAD, 8'h02, 16'h0400, ok);
    chk("R1 foreign address not acknowledged", {15'b0, ok}, 16'h0);
    chk("R1 foreign write leaves high limit", hi_l, 16'h0000);
    b_start(); tx({DEV, 1'b0}, k); b_stop();
    chk("R1 own address acknowledged", {15'b0, k}, 16'h0001);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_word(DEV, VEC[i][39:32], VEC[i][31:16], ok);
      rd_at(VEC[i][39:32], w);
      chk($sformatf("R3 R5 R6 R7 table entry %0d", i), w, VEC[i][15:0]);
    end
    chk("R7 clear pulse count", clr_cnt[15:0], 16'h0001);
    chk("R6 low limit output", lo_l, 16'h0C68);
    chk("R6 critical limit output", cr_l, 16'h1234);
    evt_act = 1;
    rd_at(8'h01, w);
    chk("R7 status bit mirrors event", w, 16'h0010);
    evt_act = 0;

    // pointer latch
    set_ptr(8'h07);
    rd_cur(w); rd_cur(w2);
    chk("R2 latched pointer first read", w, 16'h2913);
    chk("R2 no auto-increment", w2, 16'h2913);

    // short and long writes
    b_start(); tx({DEV, 1'b0}, k); tx(8'h02, k); tx(8'h55, k); b_stop();
    rd_at(8'h02, w);
    chk("R3 single data byte discarded", w, 16'h1FFC);
    b_start(); tx({DEV, 1'b0}, k); tx(8'h02, k); tx(8'h01, k); tx(8'h00, k);
    tx(8'h7F, k); tx(8'hFF, k); b_stop();
    chk("R3 extra byte acknowledged", {15'b0, k}, 16'h0001);
    rd_at(8'h02, w);
    chk("R3 extra bytes dropped", w, 16'h0100);

    // read continuation and NACK
    b_start(); tx({DEV, 1'b1}, k); rx(1'b1, b0); rx(1'b1, b1); rx(1'b1, b2); rx(1'b0, b3); b_stop();
    chk("R4 high byte first", {b0, b1}, 16'h0100);
    chk("R4 acked read repeats word", {b2, b3}, 16'h0100);
    b_start(); tx({DEV, 1'b1}, k); rx(1'b0, b0);
    chk("R4 release after NACK", {15'b0, sda_pull}, 16'h0);
    b_stop();
    rd_cur(w);
    chk("R4 read after early NACK", w, 16'h0100);

    // locks: same-write update
    wr_word(DEV, 8'h01, 16'h0100, ok);
    rd_at(8'h01, w); chk("R7 shutdown set", w, 16'h0100);
    wr_word(DEV, 8'h01, 16'h034C, ok);
    rd_at(8'h01, w); chk("R9 fields taken in locking write", w, 16'h034C);
    chk("R9 hysteresis output", {14'b0, hyst}, 16'h0001);
    wr_word(DEV, 8'h02, 16'h0FF0, ok);
    wr_word(DEV, 8'h03, 16'h0004, ok);
    rd_at(8'h02, w); chk("R8 high limit locked", w, 16'h0100);
    rd_at(8'h03, w); chk("R8 low limit locked", w, 16'h0C68);
    wr_word(DEV, 8'h01, 16'h0003, ok);
    rd_at(8'h01, w); chk("R9 R10 shutdown clears, others hold", w, 16'h024F);
    wr_word(DEV, 8'h01, 16'h0103, ok);
    rd_at(8'h01, w); chk("R9 shutdown cannot set while locked", w, 16'h024F);
    wr_word(DEV, 8'h04, 16'h0AA8, ok);
    rd_at(8'h04, w); chk("R8 critical still writable", w, 16'h0AA8);
    wr_word(DEV, 8'h01, 16'h0083, ok);
    rd_at(8'h01, w); chk("R10 critical lock set", w, 16'h02CF);
    wr_word(DEV, 8'h04, 16'h0004, ok);
    rd_at(8'h04, w); chk("R8 critical limit locked", w, 16'h0AA8);

    // reset releases locks
    rst_n = 0; repeat (4) @(negedge clk); rst_n = 1; repeat (4) @(negedge clk);
    chk("R10 locks cleared by reset", {14'b0, clock_l, elock}, 16'h0);
    wr_word(DEV, 8'h04, 16'h0008, ok);
    rd_at(8'h04, w); chk("R10 critical writable after reset", w, 16'h0008);
    fin();
  end
endmodule